// File: doc/BRIEF.md
# Change-Triggered Key Matrix Scanner

This block watches a small key matrix (five rows by six columns by default) and only starts scanning once a key has been pressed or released. While it waits, all row drives stay low, so any pressed key pulls its column low. A change in the column pattern starts the scan. The scan then walks a low level across the rows, one row at a time, and samples the active-low columns at the end of each row slot. It builds a key image from these samples. At the end of the first full pass it raises an interrupt so that a host can come and read the keys.

The host reads through a load strobe. The strobe copies the key image into a parallel snapshot, which feeds a serial shift-out stage outside this block. The same strobe drops the interrupt and forgets any key change seen during the scan. A stop command ends the scan after a short fixed latency. There is one exception: if a key changed after the first full pass and the host has not loaded since, the first stop command is used up and a second one is needed. All timing counts an oscillator enable `tick`, not the fast clock. Debouncing and pull-ups are outside the block.

Top module: `keyscan_top`

## Requirements
- R1: After reset, `row_drv` is all zeros, `irq` is 0 and `snap` is all zeros. While no scan runs, `row_drv` stays all zeros.
- R2: While idle, a change of `col_n` between two ticks starts a scan. This covers a press (a column falls) and a release (a column rises).
- R3: During a scan exactly one row is driven low and the others high. Rows are taken in index order, starting with row index 0 (`row_drv` = 11110 for the first row). Each row lasts ROW_TICKS ticks.
- R4: `irq` rises at the end of the first complete pass, ROWS*ROW_TICKS ticks after the scan begins. It then stays high until a stop takes effect or a load occurs.
- R5: An accepted stop command returns `row_drv` to all zeros and `irq` to 0 exactly STOP_TICKS ticks after the command.
- R6: If a key sample differs from the stored image after the first complete pass, the next stop command is ignored and scanning continues. A further stop command then stops the scan.
- R7: `load_snap` copies the key image to `snap`. Bit (i-1)*COLS+(j-1) holds key Sij (row i, column j, both counted from 1), and 1 means pressed. The load also drops `irq` and clears the pending key change, so a following stop is accepted.
- R8: A stop command given while idle has no effect. Rows stay low and a later key change still starts a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oscillator enable; all timing counts these |
| col_n | input | COLS | Column returns, active low |
| stop_cmd | input | 1 | Stop command strobe, one clock wide |
| load_snap | input | 1 | Read-load strobe, one clock wide |
| row_drv | output | ROWS | Row drives; the selected row is low during a scan |
| irq | output | 1 | Interrupt: a scan pass has completed |
| snap | output | ROWS*COLS | Key image snapshot for the shift-out stage |

## Verification
The bench builds the block with ROW_TICKS=4 and STOP_TICKS=3 and asserts `tick` on every other clock. A full pass is therefore twenty ticks, and the stop latency and tick gating show up within a few dozen clocks. With these short windows the bench can check the interrupt edge and the stop edge at the exact tick. It can also run several random key sets through the press/scan/load/stop/release cycle, and set up a mid-scan key change followed by two stops, all in a short run.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  typedef enum logic {
    KS_IDLE = 1'b0,
    KS_SCAN = 1'b1
  } ks_state_t;
endpackage

// File: rtl/ks_idle_watch.sv
module ks_idle_watch #(
  parameter int COLS = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            arm,
  input  logic [COLS-1:0] col_n,
  output logic            start
);
  logic [COLS-1:0] ref_q;
  logic            ref_ok;

  // Take a reference on the first idle tick, then compare on every later tick.
  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      ref_q  <= '0;
      ref_ok <= 1'b0;
      start  <= 1'b0;
    end else if (tick) begin
      ref_q  <= col_n;
      ref_ok <= 1'b1;
      start  <= ref_ok && (col_n != ref_q);
    end else begin
      start  <= 1'b0;
    end
  end

  assert_start_when_armed_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(arm));
endmodule

// File: rtl/ks_row_seq.sv
module ks_row_seq #(
  parameter int ROWS      = 5,
  parameter int ROW_TICKS = 128,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int TW = (ROW_TICKS > 1) ? $clog2(ROW_TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  output logic [RW-1:0] row_idx,
  output logic          row_end,
  output logic          cyc_end
);
  localparam logic [TW-1:0] T_LAST = TW'(ROW_TICKS - 1);
  localparam logic [RW-1:0] R_LAST = RW'(ROWS - 1);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      tcnt    <= '0;
      row_idx <= '0;
    end else if (tick) begin
      if (tcnt == T_LAST) begin
        tcnt    <= '0;
        row_idx <= (row_idx == R_LAST) ? '0 : row_idx + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign row_end = run && tick && (tcnt == T_LAST);
  assign cyc_end = row_end && (row_idx == R_LAST);

  assert_row_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (int'(row_idx) < ROWS));
endmodule

// File: rtl/ks_image.sv
module ks_image #(
  parameter int ROWS = 5,
  parameter int COLS = 6,
  localparam int KEYS = ROWS * COLS,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            row_end,
  input  logic [RW-1:0]   row_idx,
  input  logic [COLS-1:0] col_n,
  input  logic            track,
  input  logic            chg_clr,
  input  logic            load,
  output logic [KEYS-1:0] snap,
  output logic            chg
);
  logic [KEYS-1:0] image;
  logic [COLS-1:0] pressed;
  logic [COLS-1:0] stored;

  assign pressed = ~col_n;
  assign stored  = image[int'(row_idx)*COLS +: COLS];

  always_ff @(posedge clk) begin
    if (rst) begin
      image <= '0;
      snap  <= '0;
      chg   <= 1'b0;
    end else begin
      if (load) snap <= image;
      if (chg_clr) chg <= 1'b0;
      if (row_end) begin
        image[int'(row_idx)*COLS +: COLS] <= pressed;
        if (track && (pressed != stored)) chg <= 1'b1;
      end
    end
  end

  assert_chg_only_tracked_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(chg) |-> $past(track));
endmodule

// File: rtl/keyscan_top.sv
module keyscan_top #(
  parameter int ROWS       = 5,
  parameter int COLS       = 6,
  parameter int ROW_TICKS  = 128,
  parameter int STOP_TICKS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [COLS-1:0]      col_n,
  input  logic                 stop_cmd,
  input  logic                 load_snap,
  output logic [ROWS-1:0]      row_drv,
  output logic                 irq,
  output logic [ROWS*COLS-1:0] snap
);
  import keyscan_pkg::*;

  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int SW = $clog2(STOP_TICKS + 1);
  localparam logic [SW-1:0] S_LAST = SW'(STOP_TICKS - 1);

  ks_state_t     state;
  logic          scanning;
  logic          start;
  logic [RW-1:0] row_idx;
  logic          row_end;
  logic          cyc_end;
  logic          chg;
  logic          first_done;
  logic          stop_pend;
  logic [SW-1:0] stop_cnt;
  logic          stop_take;
  logic          stop_skip;
  logic          stop_fire;
  logic          first_end;

  assign scanning  = (state == KS_SCAN);
  assign stop_take = scanning && stop_cmd && !stop_pend && !chg;
  assign stop_skip = scanning && stop_cmd && !stop_pend && chg;
  assign stop_fire = scanning && stop_pend && tick && (stop_cnt == S_LAST);
  assign first_end = cyc_end && !first_done;

  ks_idle_watch #(.COLS(COLS)) u_watch (
    .clk(clk), .rst(rst), .tick(tick), .arm(!scanning),
    .col_n(col_n), .start(start)
  );

  ks_row_seq #(.ROWS(ROWS), .ROW_TICKS(ROW_TICKS)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .run(scanning),
    .row_idx(row_idx), .row_end(row_end), .cyc_end(cyc_end)
  );

  ks_image #(.ROWS(ROWS), .COLS(COLS)) u_img (
    .clk(clk), .rst(rst), .row_end(row_end), .row_idx(row_idx),
    .col_n(col_n), .track(first_done),
    .chg_clr(load_snap || stop_skip || start), .load(load_snap),
    .snap(snap), .chg(chg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= KS_IDLE;
      first_done <= 1'b0;
      stop_pend  <= 1'b0;
      stop_cnt   <= '0;
      irq        <= 1'b0;
    end else begin
      case (state)
        KS_IDLE: begin
          if (start) begin
            state      <= KS_SCAN;
            first_done <= 1'b0;
          end
        end
        default: begin
          if (first_end) first_done <= 1'b1;
          if (stop_take) begin
            stop_pend <= 1'b1;
            stop_cnt  <= '0;
          end else if (stop_fire) begin
            state     <= KS_IDLE;
            stop_pend <= 1'b0;
          end else if (stop_pend && tick) begin
            stop_cnt <= stop_cnt + 1'b1;
          end
        end
      endcase
      // A stop that completes wins; a first pass ending wins over a load.
      if (stop_fire)      irq <= 1'b0;
      else if (first_end) irq <= 1'b1;
      else if (load_snap) irq <= 1'b0;
    end
  end

  // Selected row low, all others high; all low while idle.
  assign row_drv = scanning ? ~(ROWS'(1) << row_idx) : '0;

  assert_irq_only_scanning_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> scanning);
  assert_scan_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(scanning) |-> $past(start));
  assert_stop_needs_pend_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(scanning) |-> $past(stop_pend));
  assert_load_drops_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (load_snap && !first_end) |=> !irq);
  assert_skip_keeps_running_R6: assert property (@(posedge clk) disable iff (rst)
    stop_skip |=> (scanning && !stop_pend));
endmodule

// File: tb/keyscan_top_tb.sv
module keyscan_top_tb;
  localparam int ROWS = 5;
  localparam int COLS = 6;
  localparam int KEYS = ROWS * COLS;
  localparam int RT   = 4;
  localparam int ST   = 3;
  localparam int CYC  = ROWS * RT;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tick = 1'b0;
  logic            stop_cmd = 1'b0;
  logic            load_snap = 1'b0;
  logic [KEYS-1:0] keys = '0;
  logic [COLS-1:0] col_n;
  logic [ROWS-1:0] row_drv;
  logic            irq;
  logic [KEYS-1:0] snap;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  function automatic logic [COLS-1:0] cols_of(logic [KEYS-1:0] k, logic [ROWS-1:0] r);
    logic [COLS-1:0] c;
    c = '1;
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++)
        if (k[i*COLS+j] && !r[i]) c[j] = 1'b0;
    return c;
  endfunction

  function automatic int key_bit(int row1, int col1);
    return (row1 - 1) * COLS + (col1 - 1);
  endfunction

  assign col_n = cols_of(keys, row_drv);

  keyscan_top #(.ROWS(ROWS), .COLS(COLS), .ROW_TICKS(RT), .STOP_TICKS(ST)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .col_n(col_n), .stop_cmd(stop_cmd),
    .load_snap(load_snap), .row_drv(row_drv), .irq(irq), .snap(snap)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_cmd = 1'b1;
    @(negedge clk) stop_cmd = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk) load_snap = 1'b1;
    @(negedge clk) load_snap = 1'b0;
  endtask

  task automatic wait_scan(string req);
    int n = 0;
    @(negedge clk);
    while (row_drv == '0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(req, (row_drv != '0), 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [KEYS-1:0] k;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset rows", row_drv, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset snap", snap, 0);

    // R8: stop while idle does nothing
    wait_ticks(3);
    pulse_stop();
    wait_ticks(6);
    chk("R8 idle stop rows", row_drv, 0);

    // R2/R3/R4: press S11 and time the pass
    @(negedge clk) keys = '0;
    keys[key_bit(1, 1)] = 1'b1;
    wait_scan("R2 press starts scan");
    chk("R3 first row", row_drv, 5'b11110);
    wait_ticks(RT - 1);
    chk("R3 row held", row_drv, 5'b11110);
    wait_ticks(1);
    chk("R3 second row", row_drv, 5'b11101);
    wait_ticks(CYC - RT - 1);
    chk("R4 irq before pass end", irq, 0);
    wait_ticks(1);
    chk("R4 irq at pass end", irq, 1);
    wait_ticks(10);
    chk("R4 irq held", irq, 1);

    // R6: change after first pass makes first stop ignored
    keys[key_bit(5, 3)] = 1'b1;
    wait_ticks(CYC);
    pulse_stop();
    wait_ticks(ST + 3);
    chk("R6 ignored stop rows", (row_drv != '0), 1);
    chk("R6 ignored stop irq", irq, 1);
    pulse_stop();
    wait_ticks(ST - 1);
    chk("R5 still scanning", (row_drv != '0), 1);
    wait_ticks(1);
    chk("R5 stopped rows", row_drv, 0);
    chk("R5 stopped irq", irq, 0);
    wait_ticks(2);
    pulse_load();
    chk("R7 snap order", snap, (64'd1 << key_bit(1, 1)) | (64'd1 << key_bit(5, 3)));

    // R2 release starts scan; R7 load clears pending change
    keys[key_bit(1, 1)] = 1'b0;
    wait_scan("R2 release starts scan");
    wait_ticks(CYC);
    keys[key_bit(2, 4)] = 1'b1;
    wait_ticks(CYC);
    pulse_load();
    chk("R7 snap after change", snap, (64'd1 << key_bit(5, 3)) | (64'd1 << key_bit(2, 4)));
    chk("R7 load drops irq", irq, 0);
    pulse_stop();
    wait_ticks(ST);
    chk("R7 stop accepted after load", row_drv, 0);

    // release all, then random key sets
    wait_ticks(3);
    keys = '0;
    wait_scan("R2 release all");
    wait_ticks(2 * CYC);
    pulse_stop();
    wait_ticks(ST + 2);
    chk("R5 stop after release", row_drv, 0);

    for (int it = 0; it < 5; it++) begin
      k = KEYS'($urandom()) | KEYS'(1);
      keys = k;
      wait_scan("R2 random press");
      wait_ticks(1);
      chk("R3 one row low", $countones(row_drv), ROWS - 1);
      wait_ticks(2 * CYC);
      chk("R4 irq random", irq, 1);
      pulse_load();
      chk("R7 random snap", snap, k);
      chk("R7 random irq", irq, 0);
      pulse_stop();
      wait_ticks(ST);
      chk("R5 random stop", row_drv, 0);
      wait_ticks(3);
      keys = '0;
      wait_scan("R2 random release");
      wait_ticks(2 * CYC);
      pulse_load();
      chk("R7 empty snap", snap, 0);
      pulse_stop();
      wait_ticks(ST + 2);
      chk("R1 idle rows low", row_drv, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule